// File: doc/BRIEF.md
# Packed Pixel Unpacker with Palette

The block turns a packed byte stream from video memory into 24-bit RGB pixels. It fetches bytes one at a time from a start address that software programs, and splits each byte into pixel indices of 1, 2, 4 or 8 bits. A run-time control field selects the index width. Within a byte the lowest bit group is shown first. Each index is ANDed with a programmable mask and then looked up in a colour palette. The looked-up colour is registered onto the output.

Software sets up the block through a simple write port, addressed by word offset. Palette entries sit at offsets 0x000 to 0x205, and the entry written is the offset shifted right by one. Entries 256 to 258 hold three cursor colours, which are stored but never shown. The pixel mask is at 0x240 (bits 7:0), the top-of-screen byte address is at 0x241, and the control word is at 0x242. A frame-start pulse rewinds the fetch pointer to the top of screen. A pixel is produced on each clock in which the active-display input is high.

Top module: `pix_unpack_pal`

## Requirements
- R1: Control bits 22:20 select the pixel width: code 0 gives 1 bit, code 1 gives 2 bits, code 2 gives 4 bits and code 3 gives 8 bits per pixel.
- R2: Within each fetched byte, the first pixel displayed comes from bits starting at bit 0, and each later pixel comes from the next higher group of bits.
- R3: Each unpacked index is ANDed with the mask register (offset 0x240, bits 7:0) before the palette lookup.
- R4: A write to offset N below 0x206 stores reg_wdata bits 23:16 (red), 15:8 (green) and 7:0 (blue) into palette entry N>>1. The rgb output carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: mem_addr advances by exactly one after the last pixel of the current byte has been output, which is after 8, 4, 2 or 1 active pixels depending on the mode, and never changes by more than one per cycle.
- R6: A frame_start pulse loads mem_addr with the top-of-screen register (offset 0x241) and restarts unpacking at bit 0 of that byte.
- R7: While active is low, rgb is zero one cycle later, and neither mem_addr nor the position within the byte moves.
- R8: Control codes 4 to 7 behave exactly like code 3: 8 bits per pixel, with one byte fetched per pixel.
- R9: After reset, rgb and mem_addr are zero, the control code is 0, the top of screen is 0 and the mask is 0xFF.
- R10: Writes to the cursor colour entries (offsets 0x200 to 0x205) do not change any of the 256 displayed palette entries.
- R11: An rgb value appears on the clock edge that samples active high, one register after the palette lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW (10) | Register word offset |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Rewind the fetch pointer to the top of screen |
| active | input | 1 | Active-display qualifier; one pixel per cycle while high |
| mem_addr | output | AW (24) | Byte address in video memory |
| mem_data | input | 8 | Byte at mem_addr, valid in the same cycle |
| rgb | output | 24 | Registered pixel colour |

## Verification
Two situations are hard to reach. The first is a line that stops mid-byte and later resumes: active must fall while only some of a byte's pixels have been shown. The bench drops active after a pixel count that is not a multiple of the pixels per byte. It then checks that the resumed stream continues from the same bit group and the same address. The second is the cursor entries, which cannot be seen at the outputs. To reach them, the bench writes them and then sets the mask to zero, so every pixel reads entry 0. It then shows that the displayed colour still matches the earlier value of that entry.

// File: rtl/pix_unpack_pal.sv
module pix_unpack_pal #(
  parameter int AW    = 24,
  parameter int RAW   = 10,
  parameter int CUR_N = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           frame_start,
  input  logic           active,
  output logic [AW-1:0]  mem_addr,
  input  logic [7:0]     mem_data,
  output logic [23:0]    rgb
);
  localparam int PAL_N = 256 + CUR_N;
  localparam logic [RAW-1:0] A_MASK = RAW'('h240);
  localparam logic [RAW-1:0] A_TOP  = RAW'('h241);
  localparam logic [RAW-1:0] A_CTRL = RAW'('h242);

  logic [23:0]   pal [PAL_N];
  logic [7:0]    mask_q;
  logic [AW-1:0] top_q;
  logic [2:0]    code_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    phase_q;
  logic [23:0]   rgb_q;

  logic [1:0] lg;
  logic [3:0] bpp;
  logic [2:0] last;
  logic [2:0] shamt;
  logic [7:0] fmask;
  logic [7:0] idx;
  logic       pal_we;
  logic [8:0] widx;

  assign lg     = (code_q > 3'd2) ? 2'd3 : code_q[1:0];
  assign bpp    = 4'd1 << lg;
  assign last   = 3'd7 >> lg;
  assign shamt  = 3'(phase_q << lg);
  assign fmask  = 8'((9'd1 << bpp) - 9'd1);
  assign idx    = (mem_data >> shamt) & fmask & mask_q;
  assign pal_we = reg_we && (int'(reg_addr) < 2 * PAL_N);
  assign widx   = 9'(reg_addr >> 1);

  assign mem_addr = addr_q;
  assign rgb      = rgb_q;

  always_ff @(posedge clk)
    if (pal_we) pal[widx] <= reg_wdata[23:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= 8'hFF;
      top_q   <= '0;
      code_q  <= '0;
      addr_q  <= '0;
      phase_q <= '0;
      rgb_q   <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr == A_MASK) mask_q <= reg_wdata[7:0];
        if (reg_addr == A_TOP)  top_q  <= reg_wdata[AW-1:0];
        if (reg_addr == A_CTRL) code_q <= reg_wdata[22:20];
      end
      if (frame_start) begin
        addr_q  <= top_q;
        phase_q <= '0;
        rgb_q   <= '0;
      end else if (active) begin
        rgb_q <= pal[{1'b0, idx}];
        if (phase_q >= last) begin
          addr_q  <= addr_q + AW'(1);
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 3'd1;
        end
      end else begin
        rgb_q <= '0;
      end
    end
  end

  AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || frame_start) |=> (rgb_q == 24'd0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !frame_start) |=> ($stable(addr_q) && $stable(phase_q))); // R7
  AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (addr_q == $past(top_q) && phase_q == 3'd0)); // R6
  AST_WIDE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_start && code_q >= 3'd3) |=> (addr_q == $past(addr_q) + AW'(1))); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (addr_q == $past(addr_q) || addr_q == $past(addr_q) + AW'(1))); // R5
endmodule

// File: tb/pix_unpack_pal_tb.sv
`timescale 1ns/1ps
module pix_unpack_pal_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        active = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;
  logic [23:0] rgb;

  logic [7:0]  mem [256];
  logic [23:0] pal_m [256];
  int n_checks = 0;
  int n_fail = 0;
  int m_code = 0;
  int m_top = 0;
  int m_mask = 255;
  int m_i = 0;

  always #2.5 clk = ~clk;

  assign mem_data = mem[mem_addr[7:0]];

  pix_unpack_pal dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .active(active),
    .mem_addr(mem_addr), .mem_data(mem_data), .rgb(rgb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cfg(input int code, input int top, input int mask);
    wr(10'h242, 32'(code) << 20);
    wr(10'h241, 32'(top));
    wr(10'h240, 32'(mask));
    m_code = code; m_top = top; m_mask = mask;
  endtask

  task automatic new_frame(input string tag);
    active = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_i = 0;
    chk(mem_addr == 24'(m_top), tag, 32'(mem_addr), 32'(m_top));
    chk(rgb == 24'd0, tag, 32'(rgb), 32'd0);
  endtask

  function automatic int m_bpp();
    return (m_code <= 2) ? (1 << m_code) : 8;
  endfunction

  function automatic logic [23:0] exp_px(input int i);
    int bpp = m_bpp();
    int ppb = 8 / bpp;
    int b = int'(mem[(m_top + i / ppb) % 256]);
    int f = (b >> ((i % ppb) * bpp)) & ((1 << bpp) - 1);
    return pal_m[f & m_mask];
  endfunction

  task automatic pixels(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int ea = m_top + m_i / (8 / m_bpp());
      logic [23:0] ep = exp_px(m_i);
      chk(mem_addr == 24'(ea), {tag, " addr"}, 32'(mem_addr), 32'(ea));
      active = 1'b1;
      @(negedge clk);
      chk(rgb == ep, {tag, " rgb"}, 32'(rgb), 32'(ep));
      m_i++;
    end
    active = 1'b0;
  endtask

  task automatic t_reset();
    chk(rgb == 24'd0, "R9 rgb", 32'(rgb), 32'd0);
    chk(mem_addr == 24'd0, "R9 addr", 32'(mem_addr), 32'd0);
  endtask

  task automatic t_load_palette();
    for (int k = 0; k < 256; k++) begin
      pal_m[k] = {8'(k) ^ 8'h5A, 8'(k * 3), ~8'(k)};
      wr(10'(k * 2 + (k & 1)), {8'hEE, pal_m[k]});
    end
  endtask

  task automatic t_default_mask();
    // R9: mask keeps its reset value 0xFF, R8 code 3 path
    wr(10'h242, 32'd3 << 20);
    wr(10'h241, 32'd16);
    m_code = 3; m_top = 16; m_mask = 255;
    new_frame("R6 frame");
    pixels(6, "R9 default mask");
  endtask

  task automatic t_modes();
    cfg(0, 40, 255); new_frame("R6 frame"); pixels(19, "R1 R2 R5 1bpp");
    cfg(1, 70, 255); new_frame("R6 frame"); pixels(11, "R1 R2 R5 2bpp");
    cfg(2, 90, 255); new_frame("R6 frame"); pixels(9, "R1 R2 R5 4bpp");
    cfg(3, 120, 255); new_frame("R6 frame"); pixels(5, "R1 R11 8bpp");
  endtask

  task automatic t_mask();
    cfg(3, 30, 8'h0F); new_frame("R6 frame"); pixels(6, "R3 mask 0F");
    cfg(2, 50, 8'h01); new_frame("R6 frame"); pixels(6, "R3 mask 01");
  endtask

  task automatic t_wide_codes();
    cfg(5, 140, 255); new_frame("R6 frame"); pixels(4, "R8 code5");
    cfg(7, 150, 255); new_frame("R6 frame"); pixels(4, "R8 code7");
  endtask

  task automatic t_idle_resume();
    logic [23:0] held;
    cfg(0, 60, 255); new_frame("R6 frame");
    pixels(5, "R7 before idle");
    held = mem_addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rgb == 24'd0, "R7 idle black", 32'(rgb), 32'd0);
      chk(mem_addr == held, "R7 idle addr", 32'(mem_addr), 32'(held));
    end
    pixels(9, "R7 resume");
  endtask

  task automatic t_reload();
    cfg(2, 200, 255); new_frame("R6 frame");
    pixels(7, "R6 first pass");
    new_frame("R6 reload");
    pixels(3, "R6 restart at bit 0");
  endtask

  task automatic t_cursor();
    for (int k = 0; k < 6; k++) wr(10'h200 + 10'(k), 32'h00FFFFFF);
    cfg(3, 0, 0); new_frame("R6 frame");
    pixels(4, "R10 cursor writes");
  endtask

  task automatic t_odd_offset();
    wr(10'd11, 32'hAB123456);
    pal_m[5] = 24'h123456;
    mem[230] = 8'd5;
    cfg(3, 230, 255); new_frame("R6 frame");
    pixels(1, "R4 palette write");
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 37 + 11);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_palette();
    t_default_mask();
    t_modes();
    t_mask();
    t_wide_codes();
    t_idle_resume();
    t_reload();
    t_cursor();
    t_odd_offset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule